// File: doc/BRIEF.md
# Secondary-Device Self-Test Completion Signaller

This block sits inside the second device on a shared two-device storage cable. It drives the shared "passed" handshake line that the first device watches. After any reset (power-on, software or hardware), or after a diagnostic command that is accepted, it lets go of the line at once, reports busy, and waits for the local self-test to finish. The line is active low, has a pull-up, and is wired open-collector. A passing result clears busy first. One cycle later it pulls the line low to announce the pass. A failing result clears busy and leaves the line released.

After a reset, the ready flag comes up only once the result has been announced and the local reset procedure reports done. Two deadlines are timed in prescaled ticks: a long one for the reset self-test and a shorter one for the diagnostic. When either deadline expires while the device is still busy, a sticky deadline-miss flag is set. Only the next reset event clears it. The self-test contents and the host register access are outside the block. All pins are plain control and status pins, because no data flows through the block.

Top module: `peer_diag_signal`

## Requirements
- R1: One clock edge after any of the three reset events, or after rst_n is released, the outputs are busy_o=1, ready_o=0, line_pull_o=0 (line released) and miss_o=0. Release therefore comes well inside the short deadline.
- R2: When a self-test passes, busy_o falls at the edge that samples test_done_i. line_pull_o rises exactly one edge later. line_pull_o is never 1 while busy_o is 1.
- R3: When a self-test fails (test_done_i=1 with test_pass_i=0), busy_o falls and line_pull_o stays 0 for as long as the device is not reset.
- R4: After a reset, ready_o stays 0 until the result has been announced (or the failed result recorded) and proc_done_i is 1. It then rises one edge later.
- R5: diag_cmd_i is accepted only when ready_o=1 and busy_o=0. The next edge gives busy_o=1, ready_o=1 and line_pull_o=0.
- R6: diag_cmd_i has no effect while the reset self-test is running. busy_o, ready_o and line_pull_o keep their values.
- R7: A reset event in the same cycle as diag_cmd_i, or during a diagnostic, wins: the outputs take the R1 values.
- R8: miss_o becomes 1 at the edge that samples tick number RST_LIMIT (reset self-test) or DIAG_LIMIT (diagnostic) of a busy phase. It stays 1 through later results and diagnostics. Only a reset event clears it.
- R9: Ticks count only while busy, and the count restarts at each busy phase. Ticks received while idle do not bring a later deadline closer.
- R10: test_done_i outside a busy phase is ignored: line_pull_o and busy_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset, treated as a power-on event |
| por_evt_i | input | 1 | Power-on reset event pulse |
| sw_rst_i | input | 1 | Software reset event pulse |
| hw_rst_i | input | 1 | Hardware reset pin event pulse |
| diag_cmd_i | input | 1 | Execute-diagnostic command strobe |
| tick_i | input | 1 | Prescaled time-base tick |
| test_done_i | input | 1 | Local self-test finished |
| test_pass_i | input | 1 | Self-test result, 1 = pass (valid with test_done_i) |
| proc_done_i | input | 1 | Local reset procedure complete |
| line_pull_o | output | 1 | Open-drain enable: 1 pulls the shared line low (asserted), 0 releases it |
| busy_o | output | 1 | Busy status bit |
| ready_o | output | 1 | Device-ready status bit |
| miss_o | output | 1 | Sticky deadline-miss flag |

## Verification
The hardest state to reach is a deadline miss that must then survive a later passing result and a second diagnostic, followed by a clear that only a reset may cause. The stimulus sends exactly one tick fewer than the limit and checks that the flag is still low. It then sends the final tick and carries the set flag through a pass, a fail and a reset. Before a diagnostic, idle ticks are sent so that a counter which failed to restart would expire early.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_RBUSY = 3'd0,
    ST_RCLR  = 3'd1,
    ST_RWAIT = 3'd2,
    ST_READY = 3'd3,
    ST_DBUSY = 3'd4,
    ST_DCLR  = 3'd5
  } seq_st_e;
endpackage

// File: rtl/pds_evt_merge.sv
module pds_evt_merge #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] src_i,
  output logic             any_o
);
  logic [N_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign chain[g+1] = chain[g] | src_i[g];
  end
  assign any_o = chain[N_SRC];
endmodule

// File: rtl/pds_deadline_timer.sv
module pds_deadline_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && tick_i && !start_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (start_i)                            cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != limit_i) cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i) |-> (cnt_q <= limit_i)); // R8
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/pds_seq.sv
module pds_seq
  import pds_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rst_evt_i,
  input  logic    diag_cmd_i,
  input  logic    test_done_i,
  input  logic    test_pass_i,
  input  logic    proc_done_i,
  output seq_st_e st_o,
  output logic    pull_o,
  output logic    diag_acc_o
);
  seq_st_e st_q, st_d;
  logic    pass_q, pass_d;
  logic    pull_q, pull_d;

  assign diag_acc_o = (st_q == ST_READY) && diag_cmd_i && !rst_evt_i;

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    pull_d = pull_q;
    if (rst_evt_i) begin
      st_d   = ST_RBUSY;
      pull_d = 1'b0;
      pass_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RBUSY: if (test_done_i) begin st_d = ST_RCLR; pass_d = test_pass_i; end
        ST_RCLR:  begin st_d = ST_RWAIT; pull_d = pass_q; end
        ST_RWAIT: if (proc_done_i) st_d = ST_READY;
        ST_READY: if (diag_cmd_i) begin st_d = ST_DBUSY; pull_d = 1'b0; end
        ST_DBUSY: if (test_done_i) begin st_d = ST_DCLR; pass_d = test_pass_i; end
        ST_DCLR:  begin st_d = ST_READY; pull_d = pass_q; end
        default:  begin st_d = ST_RBUSY; pull_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RBUSY;
      pass_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      pull_q <= pull_d;
    end
  end

  assign st_o   = st_q;
  assign pull_o = pull_q;

  AST_PULL_ONLY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> ($past(st_q) == ST_RCLR || $past(st_q) == ST_DCLR)); // R2
  AST_FAIL_KEEPS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RCLR || st_q == ST_DCLR) && !pass_q && !rst_evt_i) |=> !pull_q); // R3
endmodule

// File: rtl/peer_diag_signal.sv
module peer_diag_signal
  import pds_pkg::*;
#(
  parameter int RST_LIMIT  = 30000,
  parameter int DIAG_LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_evt_i,
  input  logic sw_rst_i,
  input  logic hw_rst_i,
  input  logic diag_cmd_i,
  input  logic tick_i,
  input  logic test_done_i,
  input  logic test_pass_i,
  input  logic proc_done_i,
  output logic line_pull_o,
  output logic busy_o,
  output logic ready_o,
  output logic miss_o
);
  localparam int LIM_MAX = (RST_LIMIT > DIAG_LIMIT) ? RST_LIMIT : DIAG_LIMIT;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic    rst_evt;
  logic    diag_acc;
  logic    expired;
  logic    pull;
  logic    miss_q;
  seq_st_e st;
  logic [CW-1:0] limit;

  pds_evt_merge #(.N_SRC(3)) u_merge (
    .src_i ({hw_rst_i, sw_rst_i, por_evt_i}),
    .any_o (rst_evt)
  );

  pds_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_evt_i   (rst_evt),
    .diag_cmd_i  (diag_cmd_i),
    .test_done_i (test_done_i),
    .test_pass_i (test_pass_i),
    .proc_done_i (proc_done_i),
    .st_o        (st),
    .pull_o      (pull),
    .diag_acc_o  (diag_acc)
  );

  assign busy_o  = (st == ST_RBUSY) || (st == ST_DBUSY);
  assign ready_o = (st == ST_READY) || (st == ST_DBUSY) || (st == ST_DCLR);
  assign limit   = (st == ST_DBUSY) ? CW'(DIAG_LIMIT) : CW'(RST_LIMIT);

  pds_deadline_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (rst_evt | diag_acc),
    .run_i     (busy_o),
    .tick_i    (tick_i),
    .limit_i   (limit),
    .expired_o (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       miss_q <= 1'b0;
    else if (rst_evt) miss_q <= 1'b0;
    else if (expired) miss_q <= 1'b1;
  end

  assign line_pull_o = pull;
  assign miss_o      = miss_q;

  AST_RELEASE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (!line_pull_o && busy_o && !ready_o && !miss_o)); // R1
  AST_NO_PULL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !line_pull_o); // R2
  AST_BUSY_CLEARS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_o) |-> $past(!busy_o)); // R2
  AST_READY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(proc_done_i) || $past(diag_cmd_i))); // R4
  AST_DIAG_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_cmd_i && !ready_o && !rst_evt) |=> !ready_o); // R6
  AST_MISS_CLEARS_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(miss_o) |-> $past(rst_evt)); // R8
endmodule

// File: tb/peer_diag_signal_bench.sv
module peer_diag_signal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RLIM = 8;
  localparam int DLIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 0, sw_rst = 0, hw_rst = 0, diag_cmd = 0, tick = 0;
  logic test_done = 0, test_pass = 0, proc_done = 0;
  logic line_pull, busy, ready, miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_diag_signal #(.RST_LIMIT(RLIM), .DIAG_LIMIT(DLIM)) u_peer_diag_signal (
    .clk(clk), .rst_n(rst_n), .por_evt_i(por_evt), .sw_rst_i(sw_rst),
    .hw_rst_i(hw_rst), .diag_cmd_i(diag_cmd), .tick_i(tick),
    .test_done_i(test_done), .test_pass_i(test_pass), .proc_done_i(proc_done),
    .line_pull_o(line_pull), .busy_o(busy), .ready_o(ready), .miss_o(miss)
  );

  typedef struct {
    logic  b, r, p, m;
    string tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({busy, ready, line_pull, miss} !== {e.b, e.r, e.p, e.m}) begin
          fails++;
          $display("FAIL %s: busy/ready/pull/miss actual=%b%b%b%b expected=%b%b%b%b",
                   e.tag, busy, ready, line_pull, miss, e.b, e.r, e.p, e.m);
        end
      end
    end
  end

  task automatic expect_out(input logic b, input logic r, input logic p,
                            input logic m, input string tag);
    exp_t e;
    e.b = b; e.r = r; e.p = p; e.m = m; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic done(input logic pass);
    test_done = 1'b1; test_pass = pass;
    @(negedge clk);
    test_done = 1'b0; test_pass = 1'b0;
  endtask

  task automatic diag();
    diag_cmd = 1'b1; @(negedge clk); diag_cmd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out(1, 0, 0, 0, "R1 reset state");
    ticks(3);
    expect_out(1, 0, 0, 0, "R1 still busy before result");
    done(1);
    expect_out(0, 0, 0, 0, "R2 busy clears before pull");
    step(1);
    expect_out(0, 0, 1, 0, "R2 pull one edge after busy clear");
    step(2);
    expect_out(0, 0, 1, 0, "R4 ready held without proc_done");
    proc_done = 1'b1;
    step(1);
    expect_out(0, 1, 1, 0, "R4 ready after proc_done");
    ticks(10);
    expect_out(0, 1, 1, 0, "R9 idle ticks ignored");
    done(0);
    expect_out(0, 1, 1, 0, "R10 stray test_done ignored");
    diag();
    expect_out(1, 1, 0, 0, "R5 diag accepted releases line");
    ticks(DLIM - 1);
    expect_out(1, 1, 0, 0, "R9 diag count restarted");
    ticks(1);
    expect_out(1, 1, 0, 1, "R8 diag deadline miss");
    done(1);
    expect_out(0, 1, 0, 1, "R2 diag pass busy clears first");
    step(1);
    expect_out(0, 1, 1, 1, "R8 miss sticky after pass");
    diag();
    expect_out(1, 1, 0, 1, "R5 second diag");
    done(0);
    expect_out(0, 1, 0, 1, "R3 diag fail busy clears");
    step(1);
    expect_out(0, 1, 0, 1, "R3 line stays released");
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    expect_out(1, 0, 0, 0, "R1 software reset, R8 miss cleared");
    diag();
    expect_out(1, 0, 0, 0, "R6 diag ignored in reset busy");
    step(1);
    expect_out(1, 0, 0, 0, "R6 still reset busy");
    ticks(RLIM - 1);
    expect_out(1, 0, 0, 0, "R8 one tick short of reset limit");
    ticks(1);
    expect_out(1, 0, 0, 1, "R8 reset deadline miss");
    done(0);
    expect_out(0, 0, 0, 1, "R3 reset fail busy clears");
    step(1);
    expect_out(0, 0, 0, 1, "R3 reset fail line released");
    step(1);
    expect_out(0, 1, 0, 1, "R4 ready after failed result");
    diag();
    expect_out(1, 1, 0, 1, "R5 diag from fail-ready");
    hw_rst = 1'b1; diag_cmd = 1'b1; @(negedge clk); hw_rst = 1'b0; diag_cmd = 1'b0;
    expect_out(1, 0, 0, 0, "R7 reset wins during diag");
    por_evt = 1'b1; @(negedge clk); por_evt = 1'b0;
    expect_out(1, 0, 0, 0, "R1 power-on event");
    done(1);
    step(2);
    expect_out(0, 1, 1, 0, "R4 back to ready with pull");
    hw_rst = 1'b1; diag_cmd = 1'b1; @(negedge clk); hw_rst = 1'b0; diag_cmd = 1'b0;
    expect_out(1, 0, 0, 0, "R7 reset wins over same-cycle diag");
    step(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule